// File: doc/BRIEF.md
# Keyed configuration port controller

This block sits on an ISA-style I/O bus and guards the configuration registers of a multi-function peripheral. Normally it stays in a run state, and the only address it decodes is a single configuration port. It ignores that port until an unlock key is written there. After the key, the same address acts as an index port that selects one byte of a small register file, and the next address up acts as a data port that reads or writes the selected byte. A second key written to the shared address closes access again.

The strap input is sampled for as long as reset is held. The value it has when reset is released selects one of two power-up base addresses. Firmware can move the base later by writing its low and high bytes, which are kept in two registers of the file. One register of the file drives the enable bits of the logical devices that sit behind the block. Every decode is qualified by the address-enable input.

Top module: `cfgport_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, the block is in run mode (`cfg_mode`=0), `dev_en` is 0 and the index is 0x00.
- R2: A write of 0x55 to the base address in run mode moves the block to configuration mode on the next cycle.
- R3: In run mode, a write of any other value to the base address, or any cycle not at the base address, leaves the block in run mode. Run-mode writes to the base address are claimed.
- R4: In configuration mode, a write of 0xAA to the base address returns the block to run mode and leaves the index unchanged.
- R5: In run mode, reads of the base address and all accesses to base+1 are not claimed. They return 0x00 on `io_rdata` and change no register.
- R6: In configuration mode, a write to the base address (other than 0xAA) loads the index, and a read of the base address returns the last index written.
- R7: In configuration mode, base+1 reads and writes the register selected by the index. Indices at or above the register count read 0x00 and ignore writes.
- R8: A strap level of 0 at reset release sets the base to 0x03F0, and a level of 1 sets it to 0x0370. Later strap changes have no effect.
- R9: Registers 0x26 (low byte) and 0x27 (high byte) hold the base. The cycle after either is written, only the new addresses decode.
- R10: While `aen` is high, no cycle is decoded: nothing is claimed, no state changes and `io_rdata` is 0x00.
- R11: Register contents survive leaving and re-entering configuration mode. Only reset clears them.
- R12: Register 0x22 drives `dev_en` directly, and it changes only when it is written through the data port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; strap sampled while high |
| strap | input | 1 | Base-address select strap |
| aen | input | 1 | Address enable; high blocks all decoding |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | One-cycle read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while a claimed read strobe is high, else 0 |
| io_claim | output | 1 | The current cycle is decoded by this block |
| cfg_mode | output | 1 | 1 in configuration mode |
| dev_en | output | 8 | Logical-device enable bits (register 0x22) |

## Verification
The assertions check the following on every cycle: the two key transitions, the fact that run mode holds unless the enter key arrives, the silence of the bus while `aen` is high and during run-mode reads, and the stability of the base address and device enables across cycles without a write. Only the bench scenarios can show the rest. That covers the strap choice of the power-up base, index and data round trips, the zero read of unimplemented indices, retention of registers across a close and reopen, and the old address going dead after a relocation.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
    localparam logic [7:0] KEY_ENTER   = 8'h55;
    localparam logic [7:0] KEY_EXIT    = 8'hAA;
    localparam logic [7:0] IDX_BASE_LO = 8'h26;
    localparam logic [7:0] IDX_BASE_HI = 8'h27;
    localparam logic [7:0] IDX_DEVEN   = 8'h22;

    typedef enum logic {ST_RUN = 1'b0, ST_CFG = 1'b1} cfg_state_e;

    typedef struct packed {
        logic port_wr;  // write to shared key/index address
        logic idx_rd;   // index read (config mode only)
        logic dat_wr;   // data write (config mode only)
        logic dat_rd;   // data read (config mode only)
    } cyc_dec_t;
endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
    import cfgport_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          aen,
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic [AW-1:0] base,
    input  logic          cfg_mode,
    output cyc_dec_t      dec,
    output logic          claim
);
    logic base_hit;
    logic data_hit;

    always_comb begin
        base_hit    = !aen && (io_addr == base);
        data_hit    = !aen && (io_addr == base + AW'(1));
        dec.port_wr = base_hit && io_wr;
        dec.idx_rd  = base_hit && io_rd && cfg_mode;
        dec.dat_wr  = data_hit && io_wr && cfg_mode;
        dec.dat_rd  = data_hit && io_rd && cfg_mode;
        claim       = dec.port_wr || dec.idx_rd || dec.dat_wr || dec.dat_rd;
    end
endmodule

// File: rtl/cfgport_keyfsm.sv
module cfgport_keyfsm
    import cfgport_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       port_wr,
    input  logic [7:0] wdata,
    output logic       cfg_mode,
    output logic [7:0] index
);
    typedef struct packed {
        cfg_state_e st;
        logic [7:0] idx;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (rst) begin
            fsm_d.st  = ST_RUN;
            fsm_d.idx = '0;
        end else if (port_wr) begin
            unique case (fsm_q.st)
                ST_RUN: if (wdata == KEY_ENTER) fsm_d.st = ST_CFG;
                ST_CFG: begin
                    if (wdata == KEY_EXIT) fsm_d.st  = ST_RUN;
                    else                   fsm_d.idx = wdata;
                end
                default: fsm_d.st = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) fsm_q <= fsm_d;

    assign cfg_mode = (fsm_q.st == ST_CFG);
    assign index    = fsm_q.idx;
endmodule

// File: rtl/cfgport_regfile.sv
module cfgport_regfile
    import cfgport_pkg::*;
#(
    parameter int              AW    = 16,
    parameter int              NREG  = 48,
    parameter logic [AW-1:0]   BASE0 = 16'h03F0,
    parameter logic [AW-1:0]   BASE1 = 16'h0370
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strap,
    input  logic          wr_en,
    input  logic [7:0]    index,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic [AW-1:0] base,
    output logic [7:0]    dev_en
);
    localparam int BASE_W = (AW > 16) ? 16 : AW;

    typedef struct packed {
        logic [NREG-1:0][7:0] r;
    } rf_t;

    rf_t             rf_d, rf_q;
    logic [NREG-1:0] sel;
    logic [15:0]     strap_base;

    assign strap_base = 16'(strap ? BASE1 : BASE0);

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_sel
            assign sel[g] = (index == 8'(g));
        end
    endgenerate

    always_comb begin
        rf_d = rf_q;
        if (rst) begin
            rf_d.r              = '0;
            rf_d.r[IDX_BASE_LO] = strap_base[7:0];
            rf_d.r[IDX_BASE_HI] = strap_base[15:8];
        end else if (wr_en) begin
            for (int i = 0; i < NREG; i++) begin
                if (sel[i]) rf_d.r[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) rf_q <= rf_d;

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel[i]) rdata = rf_q.r[i];
        end
    end

    assign base   = AW'({rf_q.r[IDX_BASE_HI], rf_q.r[IDX_BASE_LO]});
    assign dev_en = rf_q.r[IDX_DEVEN];

    initial begin
        if (BASE_W < 9 || NREG <= int'(IDX_BASE_HI))
            $error("cfgport_regfile: parameters leave no room for base registers");
    end
endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
    import cfgport_pkg::*;
#(
    parameter int            AW    = 16,
    parameter int            NREG  = 48,
    parameter logic [AW-1:0] BASE0 = 16'h03F0,
    parameter logic [AW-1:0] BASE1 = 16'h0370
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strap,
    input  logic          aen,
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic [7:0]    io_wdata,
    output logic [7:0]    io_rdata,
    output logic          io_claim,
    output logic          cfg_mode,
    output logic [7:0]    dev_en
);
    cyc_dec_t      dec;
    logic [AW-1:0] base_w;
    logic [7:0]    index_w;
    logic [7:0]    reg_rdata;

    cfgport_decode #(.AW(AW)) u_dec (
        .aen      (aen),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .base     (base_w),
        .cfg_mode (cfg_mode),
        .dec      (dec),
        .claim    (io_claim)
    );

    cfgport_keyfsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .port_wr  (dec.port_wr),
        .wdata    (io_wdata),
        .cfg_mode (cfg_mode),
        .index    (index_w)
    );

    cfgport_regfile #(.AW(AW), .NREG(NREG), .BASE0(BASE0), .BASE1(BASE1)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .strap  (strap),
        .wr_en  (dec.dat_wr),
        .index  (index_w),
        .wdata  (io_wdata),
        .rdata  (reg_rdata),
        .base   (base_w),
        .dev_en (dev_en)
    );

    always_comb begin
        io_rdata = '0;
        if (dec.dat_rd)      io_rdata = reg_rdata;
        else if (dec.idx_rd) io_rdata = index_w;
    end
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          aen,
    input logic [AW-1:0] io_addr,
    input logic          io_wr,
    input logic          io_rd,
    input logic [7:0]    io_wdata,
    input logic [7:0]    io_rdata,
    input logic          io_claim,
    input logic          cfg_mode,
    input logic [7:0]    dev_en,
    input logic [AW-1:0] base
);
    logic key_hit;
    assign key_hit = io_wr && !aen && (io_addr == base);

    // R2
    enter_key_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_mode && key_hit && io_wdata == 8'h55) |=> cfg_mode);

    // R3
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_mode && !(key_hit && io_wdata == 8'h55)) |=> !cfg_mode);

    // R4
    exit_key_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && key_hit && io_wdata == 8'hAA) |=> !cfg_mode);

    // R5
    run_read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_mode && io_rd) |-> (!io_claim && io_rdata == 8'h00));

    // R10
    aen_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        aen |-> (!io_claim && io_rdata == 8'h00));

    // R12
    deven_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !io_wr |=> $stable(dev_en));

    // R9
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !io_wr |=> $stable(base));
endmodule

bind cfgport_ctrl cfgport_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .aen      (aen),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .io_claim (io_claim),
    .cfg_mode (cfg_mode),
    .dev_en   (dev_en),
    .base     (base_w)
);

// File: tb/tb_cfgport_ctrl.sv
module tb_cfgport_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap = 1'b0;
    logic        aen = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_claim;
    logic        cfg_mode;
    logic [7:0]  dev_en;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    cfgport_ctrl dut (
        .clk(clk), .rst(rst), .strap(strap), .aen(aen), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_claim(io_claim), .cfg_mode(cfg_mode), .dev_en(dev_en)
    );

    // wr, rd, aen, addr, wdata, exp claim, exp rdata (reads only), exp cfg_mode before op, req
    typedef struct packed {
        logic        wr;
        logic        rd;
        logic        aen;
        logic [15:0] addr;
        logic [7:0]  data;
        logic        claim;
        logic [7:0]  rdata;
        logic        cfg;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0,1'b1,1'b0,16'h03F0,8'h00,1'b0,8'h00,1'b0,4'd5 },  // R5 run read of base
        '{1'b1,1'b0,1'b0,16'h03F1,8'h12,1'b0,8'h00,1'b0,4'd5 },  // R5 run write base+1
        '{1'b1,1'b0,1'b0,16'h03F0,8'h54,1'b1,8'h00,1'b0,4'd3 },  // R3 wrong key
        '{1'b0,1'b1,1'b0,16'h03F0,8'h00,1'b0,8'h00,1'b0,4'd3 },  // R3 still run
        '{1'b1,1'b0,1'b1,16'h03F0,8'h55,1'b0,8'h00,1'b0,4'd10},  // R10 key with aen high
        '{1'b0,1'b1,1'b0,16'h03F0,8'h00,1'b0,8'h00,1'b0,4'd10},  // R10 no entry
        '{1'b1,1'b0,1'b0,16'h03F0,8'h55,1'b1,8'h00,1'b0,4'd2 },  // R2 enter
        '{1'b0,1'b1,1'b0,16'h03F0,8'h00,1'b1,8'h00,1'b1,4'd2 },  // R2 in cfg, idx 0
        '{1'b1,1'b0,1'b0,16'h03F0,8'h22,1'b1,8'h00,1'b1,4'd6 },  // R6 index 0x22
        '{1'b0,1'b1,1'b0,16'h03F0,8'h00,1'b1,8'h22,1'b1,4'd6 },  // R6 read index
        '{1'b0,1'b1,1'b0,16'h03F1,8'h00,1'b1,8'h00,1'b1,4'd12},  // R12 reset zero
        '{1'b1,1'b0,1'b0,16'h03F1,8'hA5,1'b1,8'h00,1'b1,4'd7 },  // R7 data write
        '{1'b0,1'b1,1'b0,16'h03F1,8'h00,1'b1,8'hA5,1'b1,4'd7 },  // R7 data read
        '{1'b0,1'b1,1'b1,16'h03F1,8'h00,1'b0,8'h00,1'b1,4'd10},  // R10 aen read
        '{1'b1,1'b0,1'b0,16'h03F0,8'h26,1'b1,8'h00,1'b1,4'd8 },  // R8
        '{1'b0,1'b1,1'b0,16'h03F1,8'h00,1'b1,8'hF0,1'b1,4'd8 },  // R8 low byte
        '{1'b1,1'b0,1'b0,16'h03F0,8'h27,1'b1,8'h00,1'b1,4'd8 },  // R8
        '{1'b0,1'b1,1'b0,16'h03F1,8'h00,1'b1,8'h03,1'b1,4'd8 },  // R8 high byte
        '{1'b1,1'b0,1'b0,16'h03F0,8'h40,1'b1,8'h00,1'b1,4'd7 },  // R7 index past end
        '{1'b1,1'b0,1'b0,16'h03F1,8'h77,1'b1,8'h00,1'b1,4'd7 },  // R7 write ignored
        '{1'b0,1'b1,1'b0,16'h03F1,8'h00,1'b1,8'h00,1'b1,4'd7 },  // R7 reads zero
        '{1'b1,1'b0,1'b0,16'h03F0,8'hAA,1'b1,8'h00,1'b1,4'd4 },  // R4 exit
        '{1'b0,1'b1,1'b0,16'h03F0,8'h00,1'b0,8'h00,1'b0,4'd4 },  // R4 back in run
        '{1'b1,1'b0,1'b0,16'h03F0,8'h55,1'b1,8'h00,1'b0,4'd4 },  // R4 re-enter
        '{1'b0,1'b1,1'b0,16'h03F0,8'h00,1'b1,8'h40,1'b1,4'd4 },  // R4 index kept
        '{1'b1,1'b0,1'b0,16'h03F0,8'h22,1'b1,8'h00,1'b1,4'd11},  // R11
        '{1'b0,1'b1,1'b0,16'h03F1,8'h00,1'b1,8'hA5,1'b1,4'd11},  // R11 retained
        '{1'b1,1'b0,1'b0,16'h03F0,8'h26,1'b1,8'h00,1'b1,4'd9 },  // R9
        '{1'b1,1'b0,1'b0,16'h03F1,8'h00,1'b1,8'h00,1'b1,4'd9 },  // R9 base -> 0x0300
        '{1'b0,1'b1,1'b0,16'h03F0,8'h00,1'b0,8'h00,1'b1,4'd9 },  // R9 old base dead
        '{1'b0,1'b1,1'b0,16'h0300,8'h00,1'b1,8'h26,1'b1,4'd9 },  // R9 new base live
        '{1'b1,1'b0,1'b0,16'h0300,8'h27,1'b1,8'h00,1'b1,4'd9 },  // R9
        '{1'b1,1'b0,1'b0,16'h0301,8'h02,1'b1,8'h00,1'b1,4'd9 },  // R9 base -> 0x0200
        '{1'b0,1'b1,1'b0,16'h0301,8'h00,1'b0,8'h00,1'b1,4'd9 },  // R9 old data dead
        '{1'b0,1'b1,1'b0,16'h0201,8'h00,1'b1,8'h02,1'b1,4'd9 },  // R9 new data live
        '{1'b1,1'b0,1'b0,16'h0200,8'hAA,1'b1,8'h00,1'b1,4'd4 },  // R4 exit at new base
        '{1'b0,1'b1,1'b0,16'h0200,8'h00,1'b0,8'h00,1'b0,4'd4 },  // R4 run again
        '{1'b0,1'b1,1'b0,16'h0201,8'h00,1'b0,8'h00,1'b0,4'd5 }   // R5 data unclaimed
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_op(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.req);
        @(negedge clk);
        io_wr = v.wr; io_rd = v.rd; aen = v.aen; io_addr = v.addr; io_wdata = v.data;
        #1;
        check({tag, " cfg_mode"}, 16'(cfg_mode), 16'(v.cfg));
        check({tag, " claim"},    16'(io_claim), 16'(v.claim));
        if (v.rd) check({tag, " rdata"}, 16'(io_rdata), 16'(v.rdata));
    endtask

    task automatic idle();
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0; aen = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        strap = 1'b0;
        rst   = 1'b1;
        repeat (3) @(negedge clk);
        // R1 state held during reset
        check("R1 cfg in reset", 16'(cfg_mode), 16'h0);
        rst = 1'b0;
        strap = 1'b1;  // R8 late strap change must not matter
        @(negedge clk);
        check("R1 cfg after reset", 16'(cfg_mode), 16'h0);
        check("R1 dev_en after reset", 16'(dev_en), 16'h0);
        check("R1 claim idle", 16'(io_claim), 16'h0);

        for (int i = 0; i < NV; i++) do_op(VECS[i]);
        idle();
        // R12 enable register visible on its port
        check("R12 dev_en", 16'(dev_en), 16'h00A5);

        // Reset with strap high, from a non-reset state
        strap = 1'b1;
        rst   = 1'b1;
        repeat (2) @(negedge clk);
        rst   = 1'b0;
        strap = 1'b0;
        @(negedge clk);
        check("R1 cfg after second reset", 16'(cfg_mode), 16'h0);
        check("R11 dev_en cleared by reset", 16'(dev_en), 16'h0);
        do_op('{1'b1,1'b0,1'b0,16'h03F0,8'h55,1'b0,8'h00,1'b0,4'd8});  // R8 0x3F0 dead
        do_op('{1'b1,1'b0,1'b0,16'h0370,8'h55,1'b1,8'h00,1'b0,4'd8});  // R8 0x370 live
        do_op('{1'b0,1'b1,1'b0,16'h0370,8'h00,1'b1,8'h00,1'b1,4'd1});  // R1 index 0
        do_op('{1'b1,1'b0,1'b0,16'h0370,8'h26,1'b1,8'h00,1'b1,4'd8});
        do_op('{1'b0,1'b1,1'b0,16'h0371,8'h00,1'b1,8'h70,1'b1,4'd8});  // R8 low
        do_op('{1'b1,1'b0,1'b0,16'h0370,8'h27,1'b1,8'h00,1'b1,4'd8});
        do_op('{1'b0,1'b1,1'b0,16'h0371,8'h00,1'b1,8'h03,1'b1,4'd8});  // R8 high
        do_op('{1'b1,1'b0,1'b0,16'h0370,8'h22,1'b1,8'h00,1'b1,4'd11});
        do_op('{1'b0,1'b1,1'b0,16'h0371,8'h00,1'b1,8'h00,1'b1,4'd11}); // R11 cleared
        do_op('{1'b1,1'b0,1'b0,16'h0371,8'h3C,1'b1,8'h00,1'b1,4'd12});
        idle();
        check("R12 dev_en follows write", 16'(dev_en), 16'h003C);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule